// File: doc/BRIEF.md
# Paged Address Translation Unit with Fault Classification

This block turns a 32-bit logical address into a physical address using 4 KiB pages. Its page table is held on chip as a small array of per-page entries, and the operating system fills it in before a process runs. Each entry carries a physical frame number and a two-bit state. On a lookup, the block splits the address into a page number and a 12-bit offset. It uses the page number to select an entry. When the entry is valid, it returns the entry's frame with the offset appended.

When a page is not resident, the block does not return an address. It returns a fault code, and the code tells two cases apart. A page that was moved out to disk gives a restartable page fault, so the handler can load the page and retry the access. A page the process never owned gives an abort. Only supervisor mode may write the table. A write attempted from user mode leaves the table unchanged and is flagged as a protection fault.

A lookup is resolved combinationally and its result is registered. The response, its valid flag and its fault code all appear one clock after the request.

Top module: `paged_mmu`

## Requirements
- R1: On a lookup that does not fault, the low 12 bits of the returned physical address equal the low 12 bits of the logical address.
- R2: When the selected entry has state 01 (valid), the response is the entry's 20-bit frame number in bits 31:12, followed by the offset, with fault code 00 (none). Each entry maps on its own, so frames need not be contiguous or in order.
- R3: When the selected entry has state 10 (swapped), the response carries fault code 01 (page fault) and a physical address of zero.
- R4: When the selected entry has state 00 (unused) or 11, the response carries fault code 10 (abort) and a physical address of zero.
- R5: The table holds 16 entries, indexed by logical address bits 15:12. A logical address with any of bits 31:16 set gives fault code 10 (abort), whatever is stored in the table.
- R6: `rsp_valid_o` is high in the cycle after each cycle in which `req_valid_i` is high, and low after a cycle with no request. Back-to-back requests give back-to-back responses.
- R7: A supervisor write (`tbl_we_i` with `sup_i`=1) stores the frame and state at `tbl_idx_i`. A lookup issued in the same cycle as the write still sees the old entry. A lookup issued in the following cycle sees the new one.
- R8: A table write with `sup_i`=0 changes no entry, and `wr_fault_o` goes high for one cycle after it. A supervisor write leaves `wr_fault_o` low.
- R9: After reset, every entry is unused, and `rsp_valid_o` and `wr_fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Logical address to translate |
| tbl_we_i | input | 1 | Table write strobe |
| sup_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| tbl_idx_i | input | 4 | Entry to write |
| tbl_frame_i | input | 20 | Frame number to store |
| tbl_state_i | input | 2 | State to store (00 unused, 01 valid, 10 swapped) |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_paddr_o | output | 32 | Physical address, zero on a fault |
| rsp_fault_o | output | 2 | 00 none, 01 page fault, 10 abort |
| wr_fault_o | output | 1 | Protection fault from a user-mode table write |

## Verification
The bench drives page numbers 16 and above whose low four bits select a valid entry. A design that indexes the table without checking the upper bits would return a translation for these instead of aborting. It looks up a swapped entry and an entry in the reserved state 11. A design that merged the two non-resident kinds would turn a restartable fault into an abort, or the reverse. It writes the table from user mode and then reads back the targeted entry through a lookup, which exposes a write that leaked through the protection check. It also issues a write and a lookup to the same entry in the same cycle, which catches a table that forwards the new entry too early.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    PTE_UNUSED  = 2'b00,
    PTE_VALID   = 2'b01,
    PTE_SWAPPED = 2'b10,
    PTE_RSVD    = 2'b11
  } pte_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PAGE  = 2'b01,
    FLT_ABORT = 2'b10
  } fault_e;
endpackage

// File: rtl/mmu_page_table.sv
module mmu_page_table #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sup_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [1:0]         state_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [FRAME_W-1:0] rd_frame_o,
  output logic [1:0]         rd_state_o,
  output logic               prot_fault_o
);
  logic [ENTRIES-1:0][FRAME_W-1:0] frame_q;
  logic [ENTRIES-1:0][1:0]         state_q;
  logic                            wr_ok;

  assign wr_ok = we_i & sup_i;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_q[e] <= '0;
        state_q[e] <= 2'b00;
      end else if (wr_ok && idx_i == IDX_W'(e)) begin
        frame_q[e] <= frame_i;
        state_q[e] <= state_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prot_fault_o <= 1'b0;
    else         prot_fault_o <= we_i & ~sup_i;
  end

  // reads see pre-write contents
  assign rd_frame_o = frame_q[rd_idx_i];
  assign rd_state_o = state_q[rd_idx_i];

  assert_user_write_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sup_i) |=> ($stable(state_q) && $stable(frame_q)));

  assert_user_write_flagged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sup_i) |=> prot_fault_o);

  assert_sup_write_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || sup_i) |=> !prot_fault_o);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VADDR_W   = 32,
  parameter int PADDR_W   = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 4,
  parameter int FRAME_W   = PADDR_W - PAGE_BITS
) (
  input  logic [VADDR_W-1:0] vaddr_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [1:0]         state_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic [1:0]         fault_o
);
  localparam int HI_LSB = PAGE_BITS + IDX_W;

  logic in_range;

  assign idx_o = vaddr_i[HI_LSB-1:PAGE_BITS];

  if (HI_LSB < VADDR_W) begin : g_range
    assign in_range = ~|vaddr_i[VADDR_W-1:HI_LSB];
  end else begin : g_full
    assign in_range = 1'b1;
  end

  always_comb begin
    paddr_o = '0;
    fault_o = FLT_ABORT;
    if (in_range) begin
      unique case (state_i)
        PTE_VALID: begin
          paddr_o = {frame_i, vaddr_i[PAGE_BITS-1:0]};
          fault_o = FLT_NONE;
        end
        PTE_SWAPPED: fault_o = FLT_PAGE;
        default:     fault_o = FLT_ABORT;
      endcase
    end
  end
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import mmu_pkg::*;
#(
  parameter int VADDR_W   = 32,
  parameter int PADDR_W   = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int FRAME_W  = PADDR_W - PAGE_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VADDR_W-1:0] req_vaddr_i,
  input  logic               tbl_we_i,
  input  logic               sup_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic [1:0]         tbl_state_i,
  output logic               rsp_valid_o,
  output logic [PADDR_W-1:0] rsp_paddr_o,
  output logic [1:0]         rsp_fault_o,
  output logic               wr_fault_o
);
  localparam int HI_LSB = PAGE_BITS + IDX_W;

  logic [IDX_W-1:0]   rd_idx;
  logic [FRAME_W-1:0] rd_frame;
  logic [1:0]         rd_state;
  logic [PADDR_W-1:0] xl_paddr;
  logic [1:0]         xl_fault;

  mmu_page_table #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .FRAME_W (FRAME_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (tbl_we_i),
    .sup_i        (sup_i),
    .idx_i        (tbl_idx_i),
    .frame_i      (tbl_frame_i),
    .state_i      (tbl_state_i),
    .rd_idx_i     (rd_idx),
    .rd_frame_o   (rd_frame),
    .rd_state_o   (rd_state),
    .prot_fault_o (wr_fault_o)
  );

  mmu_xlate #(
    .VADDR_W   (VADDR_W),
    .PADDR_W   (PADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .IDX_W     (IDX_W),
    .FRAME_W   (FRAME_W)
  ) u_xlate (
    .vaddr_i (req_vaddr_i),
    .frame_i (rd_frame),
    .state_i (rd_state),
    .idx_o   (rd_idx),
    .paddr_o (xl_paddr),
    .fault_o (xl_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_paddr_o <= xl_paddr;
        rsp_fault_o <= xl_fault;
      end
    end
  end

  assert_rsp_follows_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_offset_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |->
      rsp_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0]));

  assert_fault_zero_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> rsp_paddr_o == '0);

  assert_high_page_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && |req_vaddr_i[VADDR_W-1:HI_LSB]) |=> rsp_fault_o == FLT_ABORT);
endmodule

// File: tb/sim_paged_mmu.sv
module sim_paged_mmu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        tbl_we = 1'b0;
  logic        sup = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [19:0] tbl_frame = '0;
  logic [1:0]  tbl_state = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        wr_fault;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  paged_mmu u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_vaddr_i (req_vaddr),
    .tbl_we_i    (tbl_we),
    .sup_i       (sup),
    .tbl_idx_i   (tbl_idx),
    .tbl_frame_i (tbl_frame),
    .tbl_state_i (tbl_state),
    .rsp_valid_o (rsp_valid),
    .rsp_paddr_o (rsp_paddr),
    .rsp_fault_o (rsp_fault),
    .wr_fault_o  (wr_fault)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic [1:0]  flt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_05A4, 32'h0001_A5A4, 2'b00},  // R1 R2
    '{32'h0000_1FFF, 32'h0000_3FFF, 2'b00},  // R2
    '{32'h0000_3000, 32'h0012_3000, 2'b00},  // R2 non-contiguous
    '{32'h0000_4123, 32'h000E_8123, 2'b00},  // R2
    '{32'h0000_5010, 32'h0000_0000, 2'b01},  // R3 swapped
    '{32'h0000_6010, 32'h0000_0000, 2'b10},  // R4 state 11
    '{32'h0000_2ABC, 32'h0000_0000, 2'b10},  // R4 unused
    '{32'h0000_F777, 32'hABCD_E777, 2'b00},  // R1 R2
    '{32'h0001_0000, 32'h0000_0000, 2'b10},  // R5 aliases entry 0
    '{32'hFFFF_F123, 32'h0000_0000, 2'b10},  // R5 aliases entry 15
    '{32'h0000_7000, 32'h0000_0000, 2'b10}   // R4
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input string req,
                        input logic [31:0] exp_pa, input logic [1:0] exp_f);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
    check({req, " fault"}, 64'(rsp_fault), 64'(exp_f));
  endtask

  task automatic twrite(input logic s, input logic [3:0] idx, input logic [19:0] fr,
                        input logic [1:0] st, input logic exp_wf);
    @(negedge clk);
    tbl_we = 1'b1; sup = s; tbl_idx = idx; tbl_frame = fr; tbl_state = st;
    @(negedge clk);
    tbl_we = 1'b0; sup = 1'b0;
    check("R8 wr_fault", 64'(wr_fault), 64'(exp_wf));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9 reset wr_fault", 64'(wr_fault), 64'd0);
    rst_n = 1'b1;
    lookup(32'h0000_0123, "R9 empty table", 32'h0, 2'b10);

    twrite(1'b1, 4'd0,  20'h0001A, 2'b01, 1'b0);
    twrite(1'b1, 4'd1,  20'h00003, 2'b01, 1'b0);
    twrite(1'b1, 4'd3,  20'h00123, 2'b01, 1'b0);
    twrite(1'b1, 4'd4,  20'h000E8, 2'b01, 1'b0);
    twrite(1'b1, 4'd5,  20'h00777, 2'b10, 1'b0);
    twrite(1'b1, 4'd6,  20'h00888, 2'b11, 1'b0);
    twrite(1'b1, 4'd15, 20'hABCDE, 2'b01, 1'b0);

    for (int i = 0; i < NV; i++)
      lookup(VECS[i].va, "R2/R3/R4/R5 vector", VECS[i].pa, VECS[i].flt);

    // R6: idle gives no response
    @(negedge clk);
    check("R6 idle", 64'(rsp_valid), 64'd0);

    // R6: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_1004;
    @(negedge clk);
    check("R6 b2b first", 64'(rsp_paddr), 64'h0000_3004);
    req_vaddr = 32'h0000_3008;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 b2b valid", 64'(rsp_valid), 64'd1);
    check("R6 b2b second", 64'(rsp_paddr), 64'h0012_3008);

    // R8: user write ignored, flagged
    twrite(1'b0, 4'd2, 20'h12345, 2'b01, 1'b1);
    lookup(32'h0000_2000, "R8 entry untouched", 32'h0, 2'b10);
    twrite(1'b0, 4'd0, 20'h99999, 2'b10, 1'b1);
    lookup(32'h0000_0010, "R8 valid entry kept", 32'h0001_A010, 2'b00);

    // R7: write and lookup same cycle
    @(negedge clk);
    tbl_we = 1'b1; sup = 1'b1; tbl_idx = 4'd7; tbl_frame = 20'h55555; tbl_state = 2'b01;
    req_valid = 1'b1; req_vaddr = 32'h0000_7ABC;
    @(negedge clk);
    tbl_we = 1'b0; sup = 1'b0; req_valid = 1'b0;
    check("R7 same-cycle old entry", 64'(rsp_fault), 64'd2);
    lookup(32'h0000_7ABC, "R7 next-cycle new entry", 32'h5555_5ABC, 2'b00);

    // R3 after state change to swapped
    twrite(1'b1, 4'd7, 20'h55555, 2'b10, 1'b0);
    lookup(32'h0000_7ABC, "R3 now swapped", 32'h0, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule